// File: doc/BRIEF.md
# Burst-Threshold Word FIFO Pair with Bus Requesters

This block places two small word FIFOs between a network MAC and a system bus. One FIFO holds receive data on its way to memory and the other holds transmit data on its way from memory. Each FIFO has its own requester. The requester decides when to ask the bus for a burst, states how many words the burst carries, and then counts the data beats after the grant.

The receive requester waits until the FIFO holds four words and still has room for three more. The MAC can also mark the last word of a frame. When it does, the words that remain are requested even if there are fewer than four, so the tail of a frame is not left waiting. The transmit requester asks for a four-word burst once four slots are free. It can also ask with only two slots free when the pending transfer from memory is one or two words long. The length of that pending transfer is given to the block as an input.

Both FIFOs report their word count and their full and empty state, and the receive side also reports its free space. Two sticky flags record a receive push that found the FIFO full and a transmit pop that found it empty. A synchronous clear input resets both flags.

Top module: `burst_fifo_req`

## Requirements
- R1: After reset both FIFOs are empty with count 0, the receive free space is 7, both requests are low and both error flags are low.
- R2: Each FIFO holds up to 7 words of 32 bits and returns them in the order written. The count, full and empty outputs follow every accepted push and pop, and the receive free space equals 7 minus the receive count.
- R3: Without a pending frame end, the receive request rises one cycle after the count reaches at least 4 with at least 3 free slots. It then states a length of 4. It never rises with fewer than 4 words.
- R4: A push with the frame-end marker set makes the receive request rise even with 1 to 3 words stored, with a length equal to the stored count. A grant whose length covers every stored word clears the pending frame end.
- R5: Once raised, a request and its length stay unchanged until a grant is seen.
- R6: A grant is taken only while the request is high. After it, exactly the granted number of beats is accepted, one word per beat, and a beat given outside a granted burst has no effect.
- R7: The transmit request rises when the pending length (tx_next_len) is nonzero and at least 4 slots are free. Its length is then the smaller of 4 and the pending length.
- R8: With only 2 or 3 free slots, the transmit request rises only when the pending length is 1 or 2, and its length equals the pending length. It never rises with fewer than 2 free slots or a pending length of 0.
- R9: A receive push while the FIFO is full and no word leaves is dropped. It sets a sticky overflow flag that holds until err_clr is asserted.
- R10: A transmit pop while the FIFO is empty sets a sticky underrun flag that holds until err_clr is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_clr | input | 1 | Clears both sticky error flags |
| rx_push | input | 1 | MAC writes one receive word |
| rx_wdata | input | 32 | Receive word from the MAC |
| rx_eof | input | 1 | Marks the pushed word as the last of a frame |
| rx_req | output | 1 | Receive burst request to the bus |
| rx_len | output | 3 | Words in the requested receive burst |
| rx_gnt | input | 1 | Bus grant for the receive request |
| rx_beat | input | 1 | Bus takes the head receive word |
| rx_rdata | output | 32 | Head receive word |
| rx_count | output | 3 | Receive words stored |
| rx_space | output | 3 | Receive slots free |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_ovf | output | 1 | Sticky receive overflow flag |
| tx_next_len | input | 8 | Words still to fetch for the pending transmit transfer |
| tx_req | output | 1 | Transmit burst request to the bus |
| tx_len | output | 3 | Words in the requested transmit burst |
| tx_gnt | input | 1 | Bus grant for the transmit request |
| tx_beat | input | 1 | Bus delivers one transmit word |
| tx_wdata | input | 32 | Transmit word from the bus |
| tx_pop | input | 1 | MAC takes the head transmit word |
| tx_rdata | output | 32 | Head transmit word |
| tx_count | output | 3 | Transmit words stored |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_udr | output | 1 | Sticky transmit underrun flag |

## Verification
The transmit requester is run against a table that pairs fill levels from 0 to 7 with pending lengths from 0 to 6. Some pairs fall in the four-slot case, some in the short two-slot case, some have too little room, and one has nothing pending. The table therefore separates each branch of the threshold rule and the clipping of the length to four. On the receive side, a stream without a frame end is compared with one that ends a frame after two words. This shows the four-word threshold apart from the early tail request. A word pushed after the tail burst then shows that the pending marker was cleared. Filling the receive FIFO past capacity and popping the transmit FIFO while it is empty exercise the sticky flags and their clear. Stray beats given before a grant show that they are ignored.

// File: rtl/burst_fifo_req.sv
`timescale 1ns/1ps
module burst_fifo_req #(
  parameter int WIDTH      = 32,
  parameter int DEPTH      = 7,
  parameter int BURST      = 4,
  parameter int RX_ROOM    = 3,
  parameter int SHORT_ROOM = 2,
  parameter int SHORT_MAX  = 2,
  parameter int PENDW      = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(BURST + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_clr,
  input  logic             rx_push,
  input  logic [WIDTH-1:0] rx_wdata,
  input  logic             rx_eof,
  output logic             rx_req,
  output logic [LW-1:0]    rx_len,
  input  logic             rx_gnt,
  input  logic             rx_beat,
  output logic [WIDTH-1:0] rx_rdata,
  output logic [CW-1:0]    rx_count,
  output logic [CW-1:0]    rx_space,
  output logic             rx_full,
  output logic             rx_empty,
  output logic             rx_ovf,
  input  logic [PENDW-1:0] tx_next_len,
  output logic             tx_req,
  output logic [LW-1:0]    tx_len,
  input  logic             tx_gnt,
  input  logic             tx_beat,
  input  logic [WIDTH-1:0] tx_wdata,
  input  logic             tx_pop,
  output logic [WIDTH-1:0] tx_rdata,
  output logic [CW-1:0]    tx_count,
  output logic             tx_full,
  output logic             tx_empty,
  output logic             tx_udr
);

  localparam logic [CW-1:0] FULL_C  = CW'(DEPTH);
  localparam logic [CW-1:0] BURST_C = CW'(BURST);
  localparam logic [CW-1:0] ROOM_C  = CW'(RX_ROOM);
  localparam logic [CW-1:0] SROOM_C = CW'(SHORT_ROOM);
  localparam logic [AW-1:0] LAST_P  = AW'(DEPTH - 1);

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST_P) ? '0 : p + AW'(1);
  endfunction

  // receive side
  logic [WIDTH-1:0] rx_mem [DEPTH];
  logic [AW-1:0]    rx_wp, rx_rp;
  logic [CW-1:0]    rx_cnt;
  logic [LW-1:0]    rx_left;
  logic             rx_busy, rx_eofp;
  logic             rx_wr, rx_rd, rx_thr, rx_tail;
  logic [LW-1:0]    rx_nlen;

  assign rx_rd    = rx_busy && rx_beat && (rx_cnt != '0);
  assign rx_wr    = rx_push && ((rx_cnt != FULL_C) || rx_rd);
  assign rx_space = FULL_C - rx_cnt;
  assign rx_thr   = (rx_cnt >= BURST_C) && (rx_space >= ROOM_C);
  assign rx_tail  = rx_eofp && (rx_cnt != '0);
  assign rx_nlen  = (rx_cnt >= BURST_C) ? LW'(BURST) : LW'(rx_cnt);
  assign rx_rdata = rx_mem[rx_rp];
  assign rx_count = rx_cnt;
  assign rx_full  = (rx_cnt == FULL_C);
  assign rx_empty = (rx_cnt == '0);

  always_ff @(posedge clk)
    if (rx_wr) rx_mem[rx_wp] <= rx_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      rx_req <= 1'b0; rx_len <= '0; rx_busy <= 1'b0; rx_left <= '0;
      rx_eofp <= 1'b0; rx_ovf <= 1'b0;
    end else begin
      if (rx_wr) rx_wp <= step(rx_wp);
      if (rx_rd) rx_rp <= step(rx_rp);
      case ({rx_wr, rx_rd})
        2'b10:   rx_cnt <= rx_cnt + CW'(1);
        2'b01:   rx_cnt <= rx_cnt - CW'(1);
        default: ;
      endcase
      if (!rx_busy && !rx_req && (rx_thr || rx_tail)) begin
        rx_req <= 1'b1;
        rx_len <= rx_nlen;
      end else if (rx_req && rx_gnt) begin
        rx_req  <= 1'b0;
        rx_busy <= 1'b1;
        rx_left <= rx_len;
      end else if (rx_busy && rx_beat) begin
        rx_left <= rx_left - LW'(1);
        if (rx_left == LW'(1)) rx_busy <= 1'b0;
      end
      if (rx_wr && rx_eof) rx_eofp <= 1'b1;
      else if (rx_req && rx_gnt && (CW'(rx_len) == rx_cnt)) rx_eofp <= 1'b0;
      if (rx_push && !rx_wr) rx_ovf <= 1'b1;
      else if (err_clr) rx_ovf <= 1'b0;
    end
  end

  // transmit side
  logic [WIDTH-1:0] tx_mem [DEPTH];
  logic [AW-1:0]    tx_wp, tx_rp;
  logic [CW-1:0]    tx_cnt, tx_space;
  logic [LW-1:0]    tx_left;
  logic             tx_busy, tx_bt, tx_wr, tx_rd, tx_go;
  logic [LW-1:0]    tx_nlen;

  assign tx_bt    = tx_busy && tx_beat;
  assign tx_rd    = tx_pop && (tx_cnt != '0);
  assign tx_wr    = tx_bt && ((tx_cnt != FULL_C) || tx_rd);
  assign tx_space = FULL_C - tx_cnt;
  assign tx_go    = (tx_next_len != '0) &&
                    ((tx_space >= BURST_C) ||
                     ((tx_space >= SROOM_C) && (tx_next_len <= PENDW'(SHORT_MAX))));
  assign tx_nlen  = (tx_next_len >= PENDW'(BURST)) ? LW'(BURST) : LW'(tx_next_len);
  assign tx_rdata = tx_mem[tx_rp];
  assign tx_count = tx_cnt;
  assign tx_full  = (tx_cnt == FULL_C);
  assign tx_empty = (tx_cnt == '0);

  always_ff @(posedge clk)
    if (tx_wr) tx_mem[tx_wp] <= tx_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      tx_req <= 1'b0; tx_len <= '0; tx_busy <= 1'b0; tx_left <= '0;
      tx_udr <= 1'b0;
    end else begin
      if (tx_wr) tx_wp <= step(tx_wp);
      if (tx_rd) tx_rp <= step(tx_rp);
      case ({tx_wr, tx_rd})
        2'b10:   tx_cnt <= tx_cnt + CW'(1);
        2'b01:   tx_cnt <= tx_cnt - CW'(1);
        default: ;
      endcase
      if (!tx_busy && !tx_req && tx_go) begin
        tx_req <= 1'b1;
        tx_len <= tx_nlen;
      end else if (tx_req && tx_gnt) begin
        tx_req  <= 1'b0;
        tx_busy <= 1'b1;
        tx_left <= tx_len;
      end else if (tx_bt) begin
        tx_left <= tx_left - LW'(1);
        if (tx_left == LW'(1)) tx_busy <= 1'b0;
      end
      if (tx_pop && !tx_rd) tx_udr <= 1'b1;
      else if (err_clr) tx_udr <= 1'b0;
    end
  end

  // checks
  p_rx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_req && !rx_gnt) |=> (rx_req && $stable(rx_len)));
  p_tx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && !tx_gnt) |=> (tx_req && $stable(tx_len)));
  p_rx_len_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_req |-> ((rx_len != '0) && (CW'(rx_len) <= rx_count)));
  p_rx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count <= FULL_C) && (tx_count <= FULL_C));
  p_tx_room_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> (tx_space >= SROOM_C));
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovf && !err_clr) |=> rx_ovf);
  p_udr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_udr && !err_clr) |=> tx_udr);

endmodule

// File: tb/sim_burst_fifo_req.sv
`timescale 1ns/1ps
module sim_burst_fifo_req;
  logic clk = 1'b0, rst_n = 1'b0, err_clr = 1'b0;
  logic rx_push = 1'b0, rx_eof = 1'b0, rx_gnt = 1'b0, rx_beat = 1'b0;
  logic [31:0] rx_wdata = '0, tx_wdata = '0;
  logic tx_gnt = 1'b0, tx_beat = 1'b0, tx_pop = 1'b0;
  logic [7:0] tx_next_len = '0;
  logic rx_req, rx_full, rx_empty, rx_ovf, tx_req, tx_full, tx_empty, tx_udr;
  logic [2:0] rx_len, rx_count, rx_space, tx_len, tx_count;
  logic [31:0] rx_rdata, tx_rdata;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  burst_fifo_req u0 (.*);

  // {fill count, pending length, expected request, expected length}
  localparam logic [15:0] VEC [13] = '{
    16'h0000, 16'h0111, 16'h0414, 16'h0614, 16'h3414, 16'h3212, 16'h4300,
    16'h4212, 16'h4111, 16'h5212, 16'h5300, 16'h6100, 16'h7100};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 1'b0; rx_push = 0; rx_eof = 0; rx_gnt = 0; rx_beat = 0;
    tx_gnt = 0; tx_beat = 0; tx_pop = 0; tx_next_len = '0; err_clr = 0;
    tick; tick; rst_n = 1'b1;
  endtask

  task automatic rx_put(input logic [31:0] d, input logic e);
    rx_push = 1'b1; rx_wdata = d; rx_eof = e; tick; rx_push = 1'b0; rx_eof = 1'b0;
  endtask

  task automatic rx_burst(input int n, input logic [31:0] base);
    rx_gnt = 1'b1; tick; rx_gnt = 1'b0;
    for (int i = 0; i < n; i++) begin
      chk("R2 rx order", rx_rdata, base + 32'(i));
      rx_beat = 1'b1; tick; rx_beat = 1'b0;
    end
  endtask

  task automatic tx_burst(input int n, input logic [31:0] base);
    tx_next_len = 8'(n);
    for (int k = 0; k < 8 && !tx_req; k++) tick;
    tx_gnt = 1'b1; tick; tx_gnt = 1'b0; tx_next_len = '0;
    for (int i = 0; i < n; i++) begin
      tx_beat = 1'b1; tx_wdata = base + 32'(i); tick;
    end
    tx_beat = 1'b0;
  endtask

  task automatic tx_fill(input int c);
    case (c)
      5: begin tx_burst(4, 32'h600); tx_burst(1, 32'h604); end
      6: begin tx_burst(4, 32'h600); tx_burst(2, 32'h604); end
      7: begin tx_burst(3, 32'h600); tx_burst(4, 32'h603); end
      default: if (c > 0) tx_burst(c, 32'h600);
    endcase
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset;
    // R1 reset state
    chk("R1 rx_empty", rx_empty, 1); chk("R1 rx_count", rx_count, 0);
    chk("R1 rx_space", rx_space, 7); chk("R1 tx_empty", tx_empty, 1);
    chk("R1 rx_req", rx_req, 0);     chk("R1 tx_req", tx_req, 0);
    chk("R1 rx_ovf", rx_ovf, 0);     chk("R1 tx_udr", tx_udr, 0);

    // R3 threshold, R5 hold, R6 beats
    for (int i = 0; i < 3; i++) rx_put(32'h100 + 32'(i), 1'b0);
    tick; tick; tick;
    chk("R3 no req below 4", rx_req, 0);
    chk("R2 rx_count", rx_count, 3); chk("R2 rx_space", rx_space, 4);
    rx_put(32'h103, 1'b0);
    tick;
    chk("R3 req at 4", rx_req, 1); chk("R3 len 4", rx_len, 4);
    tick; tick; tick;
    chk("R5 req held", rx_req, 1); chk("R5 len held", rx_len, 4);
    rx_beat = 1'b1; tick; rx_beat = 1'b0;
    chk("R6 stray beat ignored", rx_count, 4);
    rx_burst(4, 32'h100);
    chk("R6 rx drained", rx_count, 0); chk("R6 rx_empty", rx_empty, 1);
    chk("R6 req low", rx_req, 0);

    // R4 frame end
    rx_put(32'h200, 1'b0); rx_put(32'h201, 1'b1);
    tick;
    chk("R4 tail req", rx_req, 1); chk("R4 tail len", rx_len, 2);
    rx_burst(2, 32'h200);
    rx_put(32'h300, 1'b0);
    tick; tick; tick;
    chk("R4 marker cleared", rx_req, 0);
    rx_put(32'h301, 1'b1);
    tick;
    chk("R4 tail len 2 again", rx_len, 2); chk("R4 tail req again", rx_req, 1);

    // R9 overflow
    do_reset;
    for (int i = 0; i < 7; i++) rx_put(32'h400 + 32'(i), 1'b0);
    chk("R2 rx_full", rx_full, 1); chk("R2 rx_count 7", rx_count, 7);
    chk("R3 req raised", rx_req, 1);
    rx_put(32'h4FF, 1'b0);
    chk("R9 ovf set", rx_ovf, 1); chk("R9 count kept", rx_count, 7);
    tick; tick;
    chk("R9 ovf sticky", rx_ovf, 1);
    err_clr = 1'b1; tick; err_clr = 1'b0;
    chk("R9 ovf cleared", rx_ovf, 0);
    rx_burst(4, 32'h400);
    chk("R9 dropped word absent", rx_rdata, 32'h404);
    chk("R2 count after burst", rx_count, 3);

    // R10 underrun and transmit order
    do_reset;
    tx_pop = 1'b1; tick; tx_pop = 1'b0;
    chk("R10 udr set", tx_udr, 1); chk("R10 count 0", tx_count, 0);
    tick;
    chk("R10 udr sticky", tx_udr, 1);
    err_clr = 1'b1; tick; err_clr = 1'b0;
    chk("R10 udr cleared", tx_udr, 0);
    tx_burst(3, 32'h500);
    chk("R6 tx count", tx_count, 3); chk("R2 tx not empty", tx_empty, 0);
    for (int i = 0; i < 3; i++) begin
      chk("R2 tx order", tx_rdata, 32'h500 + 32'(i));
      tx_pop = 1'b1; tick; tx_pop = 1'b0;
    end
    chk("R2 tx empty", tx_empty, 1); chk("R10 no false udr", tx_udr, 0);

    // R7 / R8 transmit threshold table
    for (int v = 0; v < 13; v++) begin
      do_reset;
      tx_fill(int'(VEC[v][15:12]));
      chk("R2 tx fill", tx_count, 3'(VEC[v][15:12]));
      tx_next_len = 8'(VEC[v][11:8]);
      tick;
      chk("R7 R8 tx_req", tx_req, 32'(VEC[v][7:4]));
      if (VEC[v][7:4] != 0) chk("R7 R8 tx_len", tx_len, 32'(VEC[v][3:0]));
      tick; tick;
      chk("R5 tx req stable", tx_req, 32'(VEC[v][7:4]));
      if (VEC[v][15:12] == 4'h7) chk("R2 tx_full", tx_full, 1);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule